// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block serialises one PHY management transaction at a time onto an MDC clock line and a bidirectional MDIO data line. A host writes a single 32-bit management word. Its fields map one to one onto the serial frame. The block then sends a run of preamble ones followed by the word, most significant bit first. For a read, it stops driving MDIO at the turnaround and collects the sixteen bits the PHY returns. Those bits replace the low half of the same word, so the host reads the result back from the register it wrote.

An idle flag tells the host when the register is free and any read result is valid. A port-enable input gates both pins. While it is low, MDC is held low and MDIO is released. A divide-select input sets the MDC period as a multiple of the system clock, so the serial clock can be kept inside the PHY's limit. The host software performs PHY discovery and link bring-up using this register.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: A frame is 32 preamble bits of value 1, then the 32 bits of the management word from bit 31 down to bit 0, one bit per MDC period. MDIO changes only while MDC is low, so the value is steady at each MDC rising edge.
- R2: A write (wr_en high for one cycle) while idle is high and enable is high starts a frame. idle is low in the cycle after the write and stays low until the frame has finished.
- R3: Word layout from bit 31 down is: start [31:30] = 01, operation [29:28] (01 write, 10 read), PHY address [27:23], register address [22:18], code [17:16] = 10, data [15:0]. For operation 10, mdio_oe is low for frame bits 14 and 15 (turnaround) and for all 16 data bits. The 16 bits sampled at the MDC rising edges of the data bits, first bit as the MSB, replace mgmt_word[15:0]. Bits [31:16] are unchanged.
- R4: A read with no PHY responding, where the line is pulled high, returns 16'hFFFF in mgmt_word[15:0].
- R5: A write while a frame is in progress is ignored. The word and the frame on the line are unaffected.
- R6: While mgmt_en is low, mdc and mdio_oe stay low. A write while idle loads mgmt_word but sends no frame, and idle stays high.
- R7: Clearing mgmt_en during a frame abandons it. In the next cycle idle is high and both pins are quiet. A later frame runs normally.
- R8: div_sel values 0 to 5 give MDC periods of 8, 16, 32, 48, 64 and 96 system clocks, and values 6 and 7 give 96. MDC is high for exactly half of each period.
- R9: The divide ratio is captured when a frame starts. A change on div_sel during the frame does not alter that frame's MDC period.
- R10: After reset and whenever idle is high, mdc is low, mdio_oe is low and mgmt_word is zero until written.
- R11: For operation 01, mdio_oe is high for all 64 frame bits, and mgmt_word is unchanged at the end of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mgmt_en | input | 1 | Management port enable, gates the pins |
| div_sel | input | 3 | MDC divide ratio select |
| wr_en | input | 1 | Host write strobe for the management word |
| wr_data | input | 32 | Management word to send |
| mgmt_word | output | 32 | Management word register, holding the read result |
| idle | output | 1 | High when no frame is in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
A write frame with a mixed data pattern is used to check the preamble and the MSB-first ordering bit by bit, since any shift or off-by-one error shows up as a mismatch. Read frames are run in two cases. In one, a responding PHY returns a non-symmetric value, which detects reversed capture order or a capture that is off by one bit. In the other, no PHY responds, which checks the all-ones result from the pull-up. Every divide select, including the two out-of-range codes, is timed by the spacing of MDC rising edges and by the total MDC high time. Separate runs change div_sel mid-frame, write during a busy frame, write while disabled, and drop the enable mid-frame. These show that the ratio is captured at the start and that each of these events is either ignored or handled cleanly.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int FRAME_BITS = 32;
    localparam int DATA_BITS  = 16;
    localparam int SEL_W      = 3;
    localparam int MAX_HALF   = 48;
    localparam int HCNT_W     = $clog2(MAX_HALF);

    localparam logic [1:0] OP_WR = 2'b01;
    localparam logic [1:0] OP_RD = 2'b10;

    typedef struct packed {
        logic [1:0]           sof;
        logic [1:0]           op;
        logic [4:0]           phy;
        logic [4:0]           regn;
        logic [1:0]           code;
        logic [DATA_BITS-1:0] data;
    } mgmt_word_t;

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_BUSY = 1'b1
    } eng_state_t;

    // Half of the MDC period, in system clocks, for a given select code.
    function automatic logic [6:0] half_of(input logic [SEL_W-1:0] sel);
        case (sel)
            3'd0:    half_of = 7'd4;
            3'd1:    half_of = 7'd8;
            3'd2:    half_of = 7'd16;
            3'd3:    half_of = 7'd24;
            3'd4:    half_of = 7'd32;
            default: half_of = 7'd48;
        endcase
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int HCNT_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [HCNT_W-1:0] hlim,
    output logic              mdc_raw,
    output logic              rise_stb,
    output logic              fall_stb
);

    logic [HCNT_W-1:0] hcnt;
    logic              wrap;

    assign wrap = (hcnt == hlim);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            hcnt    <= '0;
            mdc_raw <= 1'b0;
        end else if (wrap) begin
            hcnt    <= '0;
            mdc_raw <= ~mdc_raw;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

    // Strobes mark the cycle whose clock edge toggles MDC.
    assign rise_stb = run && wrap && !mdc_raw;
    assign fall_stb = run && wrap &&  mdc_raw;

endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int BIDX_W  = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic                 kill,
    input  mgmt_word_t           word,
    input  logic                 rise_stb,
    input  logic                 fall_stb,
    input  logic                 mdio_i,
    output logic                 bit_out,
    output logic                 drive,
    output logic                 done,
    output logic [DATA_BITS-1:0] rdata
);

    localparam int TOTAL   = PRE_LEN + FRAME_BITS;
    localparam int LAST    = TOTAL - 1;
    localparam int TA_IDX  = PRE_LEN + 14;
    localparam int DAT_IDX = PRE_LEN + 16;

    logic [BIDX_W-1:0]     bidx;
    logic [FRAME_BITS-1:0] sreg;
    logic                  is_rd;
    logic                  active;
    logic                  in_pre;
    logic                  at_last;

    assign in_pre  = (bidx < BIDX_W'(PRE_LEN));
    assign at_last = (bidx == BIDX_W'(LAST));

    always_ff @(posedge clk) begin
        if (rst) begin
            bidx   <= '0;
            sreg   <= '0;
            is_rd  <= 1'b0;
            active <= 1'b0;
            done   <= 1'b0;
            rdata  <= '0;
        end else begin
            done <= 1'b0;
            if (load) begin
                bidx   <= '0;
                sreg   <= word;
                is_rd  <= (word.op == OP_RD);
                rdata  <= '0;
                active <= 1'b1;
            end else if (kill) begin
                active <= 1'b0;
            end else if (active) begin
                if (rise_stb && is_rd && bidx >= BIDX_W'(DAT_IDX))
                    rdata <= {rdata[DATA_BITS-2:0], mdio_i};
                if (fall_stb) begin
                    if (at_last) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        bidx <= bidx + 1'b1;
                        if (!in_pre)
                            sreg <= sreg << 1;
                    end
                end
            end
        end
    end

    assign bit_out = in_pre ? 1'b1 : sreg[FRAME_BITS-1];
    assign drive   = active && !(is_rd && bidx >= BIDX_W'(TA_IDX));

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mgmt_en,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    output logic [31:0]      mgmt_word,
    output logic             idle,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);

    localparam int TOTAL  = PRE_LEN + FRAME_BITS;
    localparam int BIDX_W = $clog2(TOTAL);

    eng_state_t            state;
    mgmt_word_t            word_q;
    logic [HCNT_W-1:0]     hlim_q;
    logic [6:0]            half_w;
    logic                  accept_wr;
    logic                  start;
    logic                  abort;
    logic                  run;
    logic                  mdc_raw;
    logic                  rise_stb;
    logic                  fall_stb;
    logic                  bit_out;
    logic                  drive;
    logic                  eng_done;
    logic [DATA_BITS-1:0]  rd_data;

    assign half_w    = half_of(div_sel);
    assign accept_wr = wr_en && (state == ENG_IDLE);
    assign start     = accept_wr && mgmt_en;
    assign abort     = (state == ENG_BUSY) && !mgmt_en;
    assign run       = (state == ENG_BUSY) && mgmt_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ENG_IDLE;
            word_q <= '0;
            hlim_q <= '0;
        end else begin
            if (accept_wr)
                word_q <= wr_data;
            if (start) begin
                state  <= ENG_BUSY;
                hlim_q <= HCNT_W'(half_w - 7'd1);
            end else if (abort) begin
                state <= ENG_IDLE;
            end else if (eng_done) begin
                state <= ENG_IDLE;
                if (word_q.op == OP_RD)
                    word_q.data <= rd_data;
            end
        end
    end

    mdio_clkgen #(
        .HCNT_W (HCNT_W)
    ) u_clkgen (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .hlim     (hlim_q),
        .mdc_raw  (mdc_raw),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_shifter #(
        .PRE_LEN (PRE_LEN),
        .BIDX_W  (BIDX_W)
    ) u_shifter (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .kill     (abort),
        .word     (mgmt_word_t'(wr_data)),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_i   (mdio_i),
        .bit_out  (bit_out),
        .drive    (drive),
        .done     (eng_done),
        .rdata    (rd_data)
    );

    assign mgmt_word = word_q;
    assign idle      = (state == ENG_IDLE);
    assign mdc       = mdc_raw && run;
    assign mdio_oe   = drive && run;
    assign mdio_o    = bit_out && mdio_oe;

endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        mgmt_en,
    input logic        wr_en,
    input logic [31:0] mgmt_word,
    input logic        idle,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        idle |-> (!mdc && !mdio_oe));

    // R6
    en_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !mgmt_en |-> (!mdc && !mdio_oe));

    // R1
    mdio_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc)) |-> $stable(mdio_o));

    // R5
    busy_wr_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (!idle && wr_en) |=> (mgmt_word[31:16] == $past(mgmt_word[31:16])));

    // R2
    start_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(idle) |-> $past(wr_en && mgmt_en));

endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mgmt_en   (mgmt_en),
    .wr_en     (wr_en),
    .mgmt_word (mgmt_word),
    .idle      (idle),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
);

// File: tb/tb_mdio_mgmt_ctrl.sv
module tb_mdio_mgmt_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic        mgmt_en;
    logic [2:0]  div_sel;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] mgmt_word;
    logic        idle;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i;

    always #10 clk = ~clk;

    mdio_mgmt_ctrl dut (
        .clk       (clk),
        .rst       (rst),
        .mgmt_en   (mgmt_en),
        .div_sel   (div_sel),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .mgmt_word (mgmt_word),
        .idle      (idle),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    int     n_chk = 0;
    int     n_fail = 0;
    longint cyc = 0;
    int     rise_idx = 0;
    int     hi_cnt = 0;
    logic   line_rec [64];
    logic   oe_rec   [64];
    longint rise_t   [64];
    bit     phy_on = 1'b0;
    logic [15:0] phy_val = 16'h0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mdc) hi_cnt <= hi_cnt + 1;
    end

    // PHY model: answers data bits after the turnaround, else pulled high.
    assign mdio_i = (phy_on && rise_idx >= 48 && rise_idx < 64) ?
                    phy_val[4'(63 - rise_idx)] : 1'b1;

    always @(posedge mdc) begin
        if (rise_idx < 64) begin
            line_rec[rise_idx] = mdio_oe ? mdio_o : mdio_i;
            oe_rec[rise_idx]   = mdio_oe;
            rise_t[rise_idx]   = cyc;
        end
        rise_idx = rise_idx + 1;
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_half(input logic [2:0] s);
        case (s)
            3'd0: return 4;
            3'd1: return 8;
            3'd2: return 16;
            3'd3: return 24;
            3'd4: return 32;
            default: return 48;
        endcase
    endfunction

    task automatic wait_idle();
        for (int i = 0; i < 10000; i++) begin
            @(negedge clk);
            if (idle) break;
        end
    endtask

    task automatic launch(input logic [31:0] w, input logic [2:0] s,
                          input bit p, input logic [15:0] pv);
        phy_on  = p;
        phy_val = pv;
        div_sel = s;
        rise_idx = 0;
        hi_cnt  = 0;
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en   = 1'b0;
        chk("R2", "idle low after write", {63'd0, idle}, 64'd0);
    endtask

    function automatic int line_errs(input logic [31:0] w, input int upto);
        int e = 0;
        for (int i = 0; i < upto; i++) begin
            logic ev;
            ev = (i < 32) ? 1'b1 : w[63 - i];
            if (line_rec[i] !== ev) e++;
        end
        return e;
    endfunction

    task automatic t_reset();
        chk("R10", "idle after reset", {63'd0, idle}, 64'd1);
        chk("R10", "mdc after reset", {63'd0, mdc}, 64'd0);
        chk("R10", "oe after reset", {63'd0, mdio_oe}, 64'd0);
        chk("R10", "word after reset", {32'd0, mgmt_word}, 64'd0);
    endtask

    task automatic t_write();
        logic [31:0] w;
        int oe_low;
        w = {2'b01, 2'b01, 5'h05, 5'h12, 2'b10, 16'hA5C3};
        launch(w, 3'd0, 1'b0, 16'h0);
        wait_idle();
        chk("R2", "idle back high", {63'd0, idle}, 64'd1);
        chk("R1", "rising edges", 64'(rise_idx), 64'd64);
        chk("R1", "bit errors on line", 64'(line_errs(w, 64)), 64'd0);
        oe_low = 0;
        for (int i = 0; i < 64; i++) if (!oe_rec[i]) oe_low++;
        chk("R11", "bits not driven", 64'(oe_low), 64'd0);
        chk("R11", "word after write", {32'd0, mgmt_word}, {32'd0, w});
    endtask

    task automatic t_read(input bit p, input logic [15:0] pv, input string req);
        logic [31:0] w;
        int oe_err;
        w = {2'b01, 2'b10, 5'h1F, 5'h02, 2'b10, 16'h0000};
        launch(w, 3'd1, p, pv);
        wait_idle();
        chk("R3", "header bit errors", 64'(line_errs(w, 46)), 64'd0);
        oe_err = 0;
        for (int i = 0; i < 64; i++) if (oe_rec[i] !== (i < 46)) oe_err++;
        chk("R3", "oe pattern errors", 64'(oe_err), 64'd0);
        chk(req, "read result", {32'd0, mgmt_word}, {32'd0, w[31:16], (p ? pv : 16'hFFFF)});
    endtask

    task automatic t_ratio();
        logic [31:0] w;
        w = {2'b01, 2'b01, 5'h01, 5'h01, 2'b10, 16'h3C5A};
        for (int s = 0; s < 8; s++) begin
            launch(w, 3'(s), 1'b0, 16'h0);
            wait_idle();
            chk("R8", "MDC period", 64'(rise_t[2] - rise_t[1]), 64'(2 * exp_half(3'(s))));
            chk("R8", "MDC high time", 64'(hi_cnt), 64'(64 * exp_half(3'(s))));
        end
    endtask

    task automatic t_latch();
        logic [31:0] w;
        w = {2'b01, 2'b01, 5'h03, 5'h04, 2'b10, 16'h0F0F};
        launch(w, 3'd0, 1'b0, 16'h0);
        repeat (20) @(negedge clk);
        div_sel = 3'd5;
        wait_idle();
        chk("R9", "period after select change", 64'(rise_t[11] - rise_t[10]), 64'd8);
    endtask

    task automatic t_busy_write();
        logic [31:0] w;
        w = {2'b01, 2'b10, 5'h0A, 5'h11, 2'b10, 16'h0000};
        launch(w, 3'd0, 1'b1, 16'h5A5A);
        repeat (100) @(negedge clk);
        wr_en = 1'b1;
        wr_data = 32'h5FFF_FFFF;
        @(negedge clk);
        wr_en = 1'b0;
        wait_idle();
        chk("R5", "edges with busy write", 64'(rise_idx), 64'd64);
        chk("R5", "word with busy write", {32'd0, mgmt_word}, {32'd0, w[31:16], 16'h5A5A});
    endtask

    task automatic t_disabled();
        int bad_idle;
        mgmt_en = 1'b0;
        rise_idx = 0;
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = 32'h5123_4567;
        @(negedge clk);
        wr_en = 1'b0;
        bad_idle = 0;
        for (int i = 0; i < 50; i++) begin
            if (!idle) bad_idle++;
            @(negedge clk);
        end
        chk("R6", "idle while disabled", 64'(bad_idle), 64'd0);
        chk("R6", "edges while disabled", 64'(rise_idx), 64'd0);
        chk("R6", "word loaded while disabled", {32'd0, mgmt_word}, 64'h5123_4567);
        mgmt_en = 1'b1;
    endtask

    task automatic t_abort();
        logic [31:0] w;
        w = {2'b01, 2'b01, 5'h07, 5'h08, 2'b10, 16'h1111};
        launch(w, 3'd0, 1'b0, 16'h0);
        repeat (200) @(negedge clk);
        mgmt_en = 1'b0;
        @(negedge clk);
        chk("R7", "idle after abort", {63'd0, idle}, 64'd1);
        chk("R7", "pins after abort", {62'd0, mdc, mdio_oe}, 64'd0);
        mgmt_en = 1'b1;
        launch(w, 3'd0, 1'b0, 16'h0);
        wait_idle();
        chk("R7", "frame after abort", 64'(line_errs(w, 64)) + 64'(rise_idx), 64'd64);
    endtask

    initial begin
        rst = 1'b1;
        mgmt_en = 1'b1;
        div_sel = 3'd0;
        wr_en = 1'b0;
        wr_data = 32'd0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write();
        t_read(1'b1, 16'h1234, "R3");
        t_read(1'b0, 16'h0000, "R4");
        t_ratio();
        t_latch();
        t_busy_write();
        t_disabled();
        t_abort();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule